// File: doc/BRIEF.md
# Contact-Latching Switch Debouncer with Auto-Rearm

This block turns the noisy contacts of a mechanical changeover switch, or of two push-buttons wired as separate "on" and "off" contacts, into clean logic levels. It behaves as a clocked set/clear bistable element. The first closure of the "on" contact latches the output high at once, without waiting for the contact to settle. Any chatter that follows is ignored. A closure of the "off" contact drops the output low in the same way.

When the output has been high for a fixed hold time, an internal timer returns the latch to idle. A deliberate second press of the same key is then seen as a new event. Each move from idle to latched emits a single-cycle press pulse, so a downstream counter counts one event per intentional press. Both contact inputs are active-low, to suit pull-up wiring, and each passes through a two-flop synchronizer. The hold time is derived from a clock-frequency parameter and a hold-time parameter in milliseconds, and the counter width follows from these. With the defaults the hold time is 0.5 s, which covers bounce trains lasting tens of milliseconds.

Top module: `contact_debounce`

## Requirements
- R1: Both raw contact inputs are active-low (0 = closed). A change on a raw input driven before clock edge k reaches the debounce decision after two synchronizer flops, so its effect on `q` first appears after edge k+2.
- R2: While idle, a new closure of the "on" contact (a 1-to-0 change of `set_n_raw`), with the "off" contact open, drives `q` high straight away. It does not wait for the contact to stop bouncing.
- R3: While `q` is high, further pulses on the "on" contact leave `q` high. They produce no press pulse and do not restart the hold timer.
- R4: A closure of the "off" contact, with the "on" contact open, drives `q` low. Later pulses on the "off" contact leave `q` low and produce no press pulse.
- R5: Unless cleared earlier, `q` stays high for exactly HOLD_CYCLES = (CLK_HZ/1000)*HOLD_MS clock cycles and then returns low on its own. Cycles in which both contacts are closed do not count towards the hold time.
- R6: After the latch has returned to idle, a new closure of the "on" contact sets `q` again with a new press pulse. A key that is held closed through the expiry does not retrigger.
- R7: In a cycle where both synchronized contacts are closed, `q` keeps its previous value and `err` goes high one cycle later. `err` then stays high until the synchronous reset.
- R8: `q_n` is always the exact inverse of `q`.
- R9: `press` is high for exactly one cycle: the first cycle in which `q` is high after being low. It is never high at any other time.
- R10: A synchronous reset (`rst` high at a clock edge) clears `q`, `press`, `err`, the hold timer and the synchronizers. After that edge, `q_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| set_n_raw | input | 1 | Raw "on" contact, active low |
| clr_n_raw | input | 1 | Raw "off" contact, active low |
| q | output | 1 | Debounced latched level |
| q_n | output | 1 | Complement of `q` |
| press | output | 1 | One-cycle pulse on each idle-to-latched change |
| err | output | 1 | Sticky flag: both contacts were closed in the same cycle |

## Verification
The hardest situation to reach from the ports is a conflict while the latch is already set. Both contacts must appear closed in the same synchronized cycle while `q` is high, and the hold timer must not run out first. The stimulus first closes the "on" contact and keeps it closed. It then closes the "off" contact a few cycles later, well inside the hold window, so that both synchronized levels overlap for several cycles. The bench checks that `q` stays high through that overlap and that `err` rises and stays set. Short hold parameters let the auto-rearm expiry, and a key held closed across it, be reached within a few dozen cycles.

// File: rtl/contact_debounce_pkg.sv
package contact_debounce_pkg;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_LATCHED = 1'b1
    } latch_state_e;

    // Active-high view of the two contacts after synchronization.
    typedef struct packed {
        logic set_on;
        logic clr_on;
    } contact_pair_t;

    // Hold time in clock cycles from clock rate (Hz) and hold time (ms).
    function automatic int unsigned hold_cycles(input int unsigned clk_hz,
                                                input int unsigned hold_ms);
        return (clk_hz / 1000) * hold_ms;
    endfunction

    function automatic int unsigned count_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Next latch state. A conflict has priority and freezes the state.
    // Otherwise a closed "off" contact clears the latch, a new "on" closure sets an
    // idle latch, and a finished hold timer returns the latch to idle.
    function automatic latch_state_e next_state(input latch_state_e cur,
                                                input logic conflict,
                                                input logic clr_on,
                                                input logic set_edge,
                                                input logic hold_done);
        latch_state_e nxt;
        nxt = cur;
        if (conflict) begin
            nxt = cur;
        end else if (clr_on) begin
            nxt = ST_IDLE;
        end else if (cur == ST_IDLE) begin
            if (set_edge) nxt = ST_LATCHED;
        end else if (hold_done) begin
            nxt = ST_IDLE;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/cd_sync.sv
module cd_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_n,
    output logic [W-1:0] lvl
);
    // Two flops per contact. The reset value is the open level (1 on the raw side).
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
            end else begin
                meta_q <= raw_n[i];
                sync_q <= meta_q;
            end
        end
        assign lvl[i] = ~sync_q;
    end
endmodule

// File: rtl/cd_edge.sv
module cd_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl_in,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl_in;
    end

    assign rise = lvl_in & ~prev_q;
endmodule

// File: rtl/cd_hold_timer.sv
module cd_hold_timer #(
    parameter int unsigned HOLD = 2,
    parameter int unsigned W    = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic freeze,
    output logic expired
);
    logic [W-1:0] cnt_q;

    assign expired = run && (cnt_q == W'(HOLD - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (!freeze && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/contact_debounce.sv
module contact_debounce
    import contact_debounce_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned HOLD_MS = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic set_n_raw,
    input  logic clr_n_raw,
    output logic q,
    output logic q_n,
    output logic press,
    output logic err
);
    localparam int unsigned HOLD_CYCLES = hold_cycles(CLK_HZ, HOLD_MS);
    localparam int unsigned CNT_W       = count_width(HOLD_CYCLES);

    contact_pair_t raw_n;
    contact_pair_t lvl;
    logic          set_lvl;
    logic          clr_lvl;
    logic          set_rise;
    logic          conflict;
    logic          tmr_done;
    latch_state_e  state_q;
    latch_state_e  state_d;
    logic          press_q;
    logic          err_q;

    assign raw_n.set_on = set_n_raw;
    assign raw_n.clr_on = clr_n_raw;

    cd_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_n (raw_n),
        .lvl   (lvl)
    );

    assign set_lvl  = lvl.set_on;
    assign clr_lvl  = lvl.clr_on;
    assign conflict = set_lvl & clr_lvl;

    cd_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_in (set_lvl),
        .rise   (set_rise)
    );

    cd_hold_timer #(.HOLD(HOLD_CYCLES), .W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q == ST_LATCHED),
        .freeze  (conflict),
        .expired (tmr_done)
    );

    always_comb begin
        state_d = next_state(state_q, conflict, clr_lvl, set_rise, tmr_done);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            press_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            press_q <= (state_q == ST_IDLE) && (state_d == ST_LATCHED);
            err_q   <= err_q | conflict;
        end
    end

    assign q     = (state_q == ST_LATCHED);
    assign q_n   = ~q;
    assign press = press_q;
    assign err   = err_q;
endmodule

// File: rtl/contact_debounce_chk.sv
module contact_debounce_chk #(
    parameter int unsigned HOLD_CYCLES = 2
) (
    input logic clk,
    input logic rst,
    input logic q,
    input logic press,
    input logic err,
    input logic set_lvl,
    input logic clr_lvl,
    input logic set_rise
);
    // Length of the current high period, not counting conflict cycles.
    int unsigned hi_run;

    always_ff @(posedge clk) begin
        if (rst || !q)                  hi_run <= 0;
        else if (!(set_lvl && clr_lvl)) hi_run <= hi_run + 1;
    end

    p_set_first_r2: assert property (@(posedge clk) disable iff (rst)
        (set_rise && !clr_lvl) |=> q);

    p_clear_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_lvl && !set_lvl) |=> !q);

    p_hold_bound_r5: assert property (@(posedge clk) disable iff (rst)
        q |-> (hi_run < HOLD_CYCLES));

    p_expire_r5: assert property (@(posedge clk) disable iff (rst)
        (q && hi_run == HOLD_CYCLES - 1 && !(set_lvl && clr_lvl)) |=> !q);

    p_conflict_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (set_lvl && clr_lvl) |=> $stable(q));

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    p_press_on_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(q) |-> press);

    p_press_needs_rise_r9: assert property (@(posedge clk) disable iff (rst)
        press |-> $rose(q));

    p_press_single_r9: assert property (@(posedge clk) disable iff (rst)
        press |=> !press);
endmodule

bind contact_debounce contact_debounce_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .q        (q),
    .press    (press),
    .err      (err),
    .set_lvl  (set_lvl),
    .clr_lvl  (clr_lvl),
    .set_rise (set_rise)
);

// File: tb/contact_debounce_tb_top.sv
`timescale 1ns/1ps
module contact_debounce_tb_top;
    localparam int unsigned TB_CLK_HZ  = 20000;
    localparam int unsigned TB_HOLD_MS = 2;
    localparam int HOLD = (TB_CLK_HZ / 1000) * TB_HOLD_MS; // R5 formula: 40 cycles

    typedef struct {
        int    at;
        bit    q;
        bit    press;
        bit    err;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst;
    logic set_n, clr_n;
    logic q, q_n, press, err;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    item_t exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    contact_debounce #(.CLK_HZ(TB_CLK_HZ), .HOLD_MS(TB_HOLD_MS)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .set_n_raw (set_n),
        .clr_n_raw (clr_n),
        .q         (q),
        .q_n       (q_n),
        .press     (press),
        .err       (err)
    );

    task automatic expect_at(input int at, input bit eq, input bit ep, input bit ee,
                             input string tag);
        item_t it;
        it.at = at; it.q = eq; it.press = ep; it.err = ee; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares queued expectations in their cycle; checks R8 every cycle.
    always @(negedge clk) begin
        if (rst === 1'b0) begin
            checks++;
            if (q_n !== ~q) begin
                fails++;
                $display("FAIL R8 cyc %0d: q_n=%b expected %b", cyc, q_n, ~q);
            end
        end
        while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (it.at != cyc) begin
                fails++;
                $display("FAIL %s: sampled at cyc %0d expected cyc %0d", it.tag, cyc, it.at);
            end else if (q !== it.q || press !== it.press || err !== it.err || q_n !== ~it.q) begin
                fails++;
                $display("FAIL %s cyc %0d: q/q_n/press/err=%b%b%b%b expected %b%b%b%b",
                         it.tag, cyc, q, q_n, press, err, it.q, ~it.q, it.press, it.err);
            end
        end
    end

    initial begin
        int t;
        rst = 1'b1; set_n = 1'b1; clr_n = 1'b1;
        fork
            begin
                step(3);
                t = cyc;
                rst = 1'b0;
                expect_at(t + 1, 0, 0, 0, "R10 reset state");
                step(3);

                // R1 R2 R3 R5 R9: first closure, bounce, automatic expiry
                t = cyc;
                expect_at(t + 2, 0, 0, 0, "R1 two-flop latency");
                expect_at(t + 3, 1, 1, 0, "R2 R9 first closure sets");
                expect_at(t + 4, 1, 0, 0, "R9 pulse lasts one cycle");
                for (int k = 8; k <= 12; k++) expect_at(t + k, 1, 0, 0, "R3 bounce ignored");
                expect_at(t + 3 + HOLD - 1, 1, 0, 0, "R5 still held at last cycle");
                expect_at(t + 3 + HOLD, 0, 0, 0, "R5 auto-rearm");
                set_n = 1'b0; step(4);
                set_n = 1'b1; step(1);
                set_n = 1'b0; step(1);
                set_n = 1'b1; step(1);
                set_n = 1'b0; step(2);
                set_n = 1'b1;
                step(HOLD + 5);

                // R6: key held across expiry does not retrigger
                t = cyc;
                expect_at(t + 3, 1, 1, 0, "R6 press registers");
                expect_at(t + 3 + HOLD, 0, 0, 0, "R5 expiry while held");
                expect_at(t + 45, 0, 0, 0, "R6 held key no retrigger");
                expect_at(t + 55, 0, 0, 0, "R6 held key no retrigger");
                set_n = 1'b0; step(58);
                set_n = 1'b1; step(5);

                // R6 repeat press, then R4 clear with bounce
                t = cyc;
                expect_at(t + 3, 1, 1, 0, "R6 repeat press");
                expect_at(t + 12, 1, 0, 0, "R4 clear latency");
                expect_at(t + 13, 0, 0, 0, "R4 clear closure");
                expect_at(t + 14, 0, 0, 0, "R4 clear bounce ignored");
                expect_at(t + 16, 0, 0, 0, "R4 clear bounce ignored");
                expect_at(t + 20, 0, 0, 0, "R4 clear bounce ignored");
                set_n = 1'b0; step(3);
                set_n = 1'b1; step(7);
                clr_n = 1'b0; step(2);
                clr_n = 1'b1; step(1);
                clr_n = 1'b0; step(2);
                clr_n = 1'b1; step(10);

                // R7 conflict while idle
                t = cyc;
                expect_at(t + 2, 0, 0, 0, "R7 no early flag");
                expect_at(t + 3, 0, 0, 1, "R7 conflict holds idle");
                expect_at(t + 4, 0, 0, 1, "R7 conflict holds idle");
                expect_at(t + 12, 0, 0, 1, "R7 sticky flag");
                set_n = 1'b0; clr_n = 1'b0; step(5);
                set_n = 1'b1; clr_n = 1'b1; step(10);

                // R7 conflict while latched, then R10 reset
                t = cyc;
                expect_at(t + 3, 1, 1, 1, "R7 set with flag high");
                expect_at(t + 9, 1, 0, 1, "R7 conflict holds latched");
                expect_at(t + 11, 1, 0, 1, "R7 conflict holds latched");
                expect_at(t + 16, 0, 0, 0, "R10 reset clears latch and flag");
                expect_at(t + 20, 0, 0, 0, "R10 idle after reset");
                set_n = 1'b0; step(5);
                clr_n = 1'b0; step(5);
                clr_n = 1'b1; step(2);
                set_n = 1'b1; step(3);
                rst = 1'b1; step(2);
                rst = 1'b0; step(8);
            end
            begin
                repeat (5000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: cyc %0d expected run under 5000", cyc);
            end
        join_any
        disable fork;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL pending: %0d expectations left expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule